// File: doc/BRIEF.md
# USB Device Suspend State Controller

This block tracks the power-management state of a full-speed USB device function and tells external circuitry when the function is suspended. It takes bus-condition flags from a line-state monitor: bus idle, resume signalling seen, and bus reset seen. It also takes a local remote-wakeup request, a flag from the enumeration logic that says configuration is complete, and an active-low external reset pin. It drives two suspend indications of opposite polarity and a request that tells the transceiver to send resume signalling upstream.

From power-on, and after any qualified external reset, the indications show "suspended" until the configuration flag is set. Once the function is active, a long idle period on the bus moves it into suspend. Any of three events brings it out again: resume signalling from the host, a bus reset, or a wake-up that the function starts itself. In the last case the block drives resume for a programmed time. The external reset pin only counts when it stays low for a minimum time, so short glitches are filtered out.

Top module: `usb_suspend_ctrl`

## Requirements
- R1: While active, the block enters suspend once the synchronised idle flag has been high for IDLE_CYC consecutive cycles; any cycle with the flag low, or with bus reset seen, restarts the count.
- R2: `suspend_hi` is 1 and `suspend_lo_n` is 0 whenever the block is suspended or unconfigured; otherwise they are 0 and 1; the two are never equal.
- R3: After `rst_n` or a qualified device reset, the indications stay asserted until `cfg_done` is 1; `cfg_done` is sampled directly, with no synchroniser.
- R4: In suspend, resume signalling seen on the bus (`line_resume`) returns the block to active, and the suspend indications are released.
- R5: In suspend, a bus reset seen on the bus (`line_reset`) returns the block to active, and the suspend indications are released.
- R6: `wake_req` in suspend releases the indications and raises `resume_drive` for exactly max(`resume_ms`,1) x CYC_PER_MS cycles; after that the block is active. `wake_req` outside suspend has no effect.
- R7: A low level on `ext_rst_n` acts as a device reset only after it has been seen low for RST_MIN_CYC consecutive synchronised cycles. A shorter low pulse changes no output. While the qualified reset lasts, the block is held unconfigured.
- R8: `line_idle`, `line_resume`, `line_reset` and `ext_rst_n` pass through two flip-flops. A change at an input edge reaches the outputs at the third rising edge after it.
- R9: `resume_ms` is captured when the resume drive starts; changing it during the drive leaves the drive length unchanged.
- R10: A bus reset seen while resume is being driven ends the drive early and returns the block to active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (48 MHz by default) |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low, width-qualified |
| line_idle | input | 1 | Line monitor: bus is in the idle state |
| line_resume | input | 1 | Line monitor: resume signalling seen |
| line_reset | input | 1 | Line monitor: bus reset seen |
| wake_req | input | 1 | Local remote-wakeup request |
| cfg_done | input | 1 | Enumeration logic: configuration complete |
| resume_ms | input | 4 | Resume drive length in milliseconds (0 is treated as 1) |
| suspend_hi | output | 1 | Suspend indication, high when suspended |
| suspend_lo_n | output | 1 | Suspend indication, low when suspended |
| resume_drive | output | 1 | Request to drive resume signalling on the bus |

## Verification
The bench builds the block with RST_MIN_CYC=8, IDLE_CYC=24 and CYC_PER_MS=3, in place of the 720, 144000 and 48000 used at 48 MHz. These values let a full suspend entry take a few dozen cycles and a full 15 ms resume drive take 45 cycles. They also let a reset pulse sit just below and well above the qualifying width. With them the bench reaches every state change several times, including the idle-restart case, the aborted resume drive and the reset filter at both sides of its threshold, within a short run.

// File: rtl/usbsc_pkg.sv
package usbsc_pkg;

  typedef enum logic [1:0] {
    ST_UNCFG  = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_SUSP   = 2'd2,
    ST_RESUME = 2'd3
  } pm_state_t;

  // Resume drive length in cycles; a zero request is widened to one millisecond.
  function automatic int unsigned resume_cycles(input logic [3:0] ms, input int unsigned per_ms);
    int unsigned m;
    m = (ms == 4'd0) ? 32'd1 : 32'(ms);
    return m * per_ms;
  endfunction

  function automatic logic is_suspended(input pm_state_t s);
    return (s == ST_UNCFG) || (s == ST_SUSP);
  endfunction

endpackage

// File: rtl/usbsc_sync.sv
module usbsc_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/usbsc_rst_qual.sv
module usbsc_rst_qual #(
  parameter int MIN_CYC = 720
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  output logic dev_rst
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_CYC);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_cnt <= '0;
    else if (pin_s)            low_cnt <= '0;
    else if (low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
  end

  assign dev_rst = (low_cnt == LIMIT);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pin_s |=> !dev_rst);
  p_qual_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_rst) |-> $past(!pin_s));
endmodule

// File: rtl/usbsc_idle_tmr.sv
module usbsc_idle_tmr #(
  parameter int IDLE_CYC = 144000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic idle_s,
  output logic susp_det
);
  localparam int CW = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYC);

  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 idle_cnt <= '0;
    else if (clr || !idle_s)    idle_cnt <= '0;
    else if (idle_cnt != LIMIT) idle_cnt <= idle_cnt + 1'b1;
  end

  assign susp_det = (idle_cnt == LIMIT);

  p_idle_hist_r1: assert property (@(posedge clk) disable iff (!rst_n)
    susp_det |-> $past(idle_s && !clr));
endmodule

// File: rtl/usbsc_pm_fsm.sv
module usbsc_pm_fsm
  import usbsc_pkg::*;
#(
  parameter int CYC_PER_MS = 48000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      dev_rst,
  input  logic      cfg_done,
  input  logic      susp_det,
  input  logic      res_s,
  input  logic      brst_s,
  input  logic      wake_req,
  input  logic [3:0] resume_ms,
  output pm_state_t state_q,
  output logic      sus_hi,
  output logic      sus_lo_n,
  output logic      res_drv
);
  localparam int RCW = $clog2(15 * CYC_PER_MS + 1);

  pm_state_t      state_nxt;
  logic [RCW-1:0] rcnt_q, rcnt_nxt;

  always_comb begin
    state_nxt = state_q;
    rcnt_nxt  = rcnt_q;
    if (dev_rst) begin
      state_nxt = ST_UNCFG;
    end else begin
      unique case (state_q)
        ST_UNCFG:  if (cfg_done) state_nxt = ST_ACTIVE;
        ST_ACTIVE: if (susp_det) state_nxt = ST_SUSP;
        ST_SUSP: begin
          if (res_s || brst_s) begin
            state_nxt = ST_ACTIVE;
          end else if (wake_req) begin
            state_nxt = ST_RESUME;
            rcnt_nxt  = RCW'(resume_cycles(resume_ms, CYC_PER_MS) - 1);
          end
        end
        ST_RESUME: begin
          if (brst_s || rcnt_q == '0) state_nxt = ST_ACTIVE;
          else                        rcnt_nxt  = rcnt_q - 1'b1;
        end
        default: state_nxt = ST_UNCFG;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_UNCFG;
      rcnt_q   <= '0;
      sus_hi   <= 1'b1;
      sus_lo_n <= 1'b0;
      res_drv  <= 1'b0;
    end else begin
      state_q  <= state_nxt;
      rcnt_q   <= rcnt_nxt;
      sus_hi   <= is_suspended(state_nxt);
      sus_lo_n <= !is_suspended(state_nxt);
      res_drv  <= (state_nxt == ST_RESUME);
    end
  end

  p_complement_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sus_hi != sus_lo_n);
  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_UNCFG && !cfg_done) |=> sus_hi);
  p_bus_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SUSP && res_s && !dev_rst) |=> !sus_hi);
  p_bus_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SUSP || state_q == ST_RESUME) && brst_s && !dev_rst) |=> (!sus_hi && !res_drv));
  p_drive_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_drv) |-> $past(state_q == ST_SUSP && wake_req));
  p_devrst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |=> sus_hi);
endmodule

// File: rtl/usb_suspend_ctrl.sv
module usb_suspend_ctrl
  import usbsc_pkg::*;
#(
  parameter int RST_MIN_CYC = 720,
  parameter int IDLE_CYC    = 144000,
  parameter int CYC_PER_MS  = 48000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_rst_n,
  input  logic       line_idle,
  input  logic       line_resume,
  input  logic       line_reset,
  input  logic       wake_req,
  input  logic       cfg_done,
  input  logic [3:0] resume_ms,
  output logic       suspend_hi,
  output logic       suspend_lo_n,
  output logic       resume_drive
);
  logic [2:0] line_s;
  logic       pin_s;
  logic       idle_s, res_s, brst_s;
  logic       dev_rst_evt;
  logic       susp_det_evt;
  logic       idle_clr;
  pm_state_t  state;

  usbsc_sync #(.W(3), .RST_VAL(3'b000)) u_line_sync (
    .clk(clk), .rst_n(rst_n),
    .d({line_idle, line_resume, line_reset}), .q(line_s)
  );
  usbsc_sync #(.W(1), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_rst_n), .q(pin_s)
  );

  assign idle_s = line_s[2];
  assign res_s  = line_s[1];
  assign brst_s = line_s[0];

  usbsc_rst_qual #(.MIN_CYC(RST_MIN_CYC)) u_rst_qual (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .dev_rst(dev_rst_evt)
  );

  assign idle_clr = (state != ST_ACTIVE) || brst_s;

  usbsc_idle_tmr #(.IDLE_CYC(IDLE_CYC)) u_idle_tmr (
    .clk(clk), .rst_n(rst_n), .clr(idle_clr), .idle_s(idle_s), .susp_det(susp_det_evt)
  );

  usbsc_pm_fsm #(.CYC_PER_MS(CYC_PER_MS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst_evt), .cfg_done(cfg_done),
    .susp_det(susp_det_evt), .res_s(res_s), .brst_s(brst_s),
    .wake_req(wake_req), .resume_ms(resume_ms), .state_q(state),
    .sus_hi(suspend_hi), .sus_lo_n(suspend_lo_n), .res_drv(resume_drive)
  );

  p_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && susp_det_evt && !dev_rst_evt) |=> suspend_hi);
  p_no_drive_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE) |=> !resume_drive);
endmodule

// File: tb/usb_suspend_ctrl_tb_top.sv
`timescale 1ns/1ps
module usb_suspend_ctrl_tb_top;
  localparam int RMIN  = 8;
  localparam int IDLE  = 24;
  localparam int PERMS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0, ext_rst_n = 1'b1;
  logic line_idle = 1'b0, line_resume = 1'b0, line_reset = 1'b0;
  logic wake_req = 1'b0, cfg_done = 1'b0;
  logic [3:0] resume_ms = 4'd2;
  logic suspend_hi, suspend_lo_n, resume_drive;

  int checks = 0, errors = 0;
  string phase = "R3";

  always #2.5 clk = ~clk;

  usb_suspend_ctrl #(.RST_MIN_CYC(RMIN), .IDLE_CYC(IDLE), .CYC_PER_MS(PERMS)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .line_idle(line_idle),
    .line_resume(line_resume), .line_reset(line_reset), .wake_req(wake_req),
    .cfg_done(cfg_done), .resume_ms(resume_ms), .suspend_hi(suspend_hi),
    .suspend_lo_n(suspend_lo_n), .resume_drive(resume_drive)
  );

  // Reference model: 0 unconfigured, 1 active, 2 suspended, 3 driving resume
  int m_state = 0, low_run = 0, idle_run = 0, remain = 0;
  logic [3:0] hist[$] = '{4'b0001, 4'b0001}; // {idle, resume, reset, pin}

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; low_run = 0; idle_run = 0; remain = 0;
      hist = '{4'b0001, 4'b0001};
    end else begin
      logic [3:0] old;
      int ns;
      old = hist[0];
      ns = m_state;
      if (low_run >= RMIN) ns = 0;
      else if (m_state == 0) begin
        if (cfg_done) ns = 1;
      end else if (m_state == 1) begin
        if (idle_run >= IDLE) ns = 2;
      end else if (m_state == 2) begin
        if (old[2] || old[1]) ns = 1;
        else if (wake_req) begin
          ns = 3;
          remain = ((resume_ms == 0) ? 1 : int'(resume_ms)) * PERMS;
        end
      end else begin
        if (old[1]) ns = 1;
        else begin
          remain--;
          if (remain == 0) ns = 1;
        end
      end
      low_run  = old[0] ? 0 : low_run + 1;
      idle_run = (m_state != 1 || old[1] || !old[3]) ? 0 : idle_run + 1;
      m_state  = ns;
      void'(hist.pop_front());
      hist.push_back({line_idle, line_resume, line_reset, ext_rst_n});
    end
  end

  always @(negedge clk) begin
    logic e_hi, e_drv;
    e_hi  = (m_state == 0) || (m_state == 2);
    e_drv = (m_state == 3);
    checks++;
    if (suspend_hi !== e_hi || suspend_lo_n !== !e_hi || resume_drive !== e_drv) begin
      errors++;
      $display("FAIL %s/R2 per-cycle: hi=%b lo_n=%b drv=%b expected hi=%b lo_n=%b drv=%b",
               phase, suspend_hi, suspend_lo_n, resume_drive, e_hi, !e_hi, e_drv);
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_suspend();
    line_idle = 1'b1;
    cyc(IDLE + 6);
    line_idle = 1'b0;
  endtask

  task automatic count_drive(input int win, output int n);
    n = 0;
    for (int i = 0; i < win; i++) begin
      if (resume_drive) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int n;
    cyc(3);
    chk(suspend_hi == 1 && suspend_lo_n == 0, "R3 reset state", suspend_hi, 1);
    rst_n = 1'b1;

    phase = "R3";
    cyc(10);
    chk(suspend_hi == 1, "R3 held until configured", suspend_hi, 1);
    cfg_done = 1'b1;
    cyc(3);
    chk(suspend_hi == 0 && suspend_lo_n == 1, "R3 released by config", suspend_hi, 0);

    phase = "R1";
    line_idle = 1'b1; cyc(IDLE - 4);
    line_idle = 1'b0; cyc(1);
    line_idle = 1'b1; cyc(IDLE - 4);
    chk(suspend_hi == 0, "R1 idle count restarted", suspend_hi, 0);
    cyc(10);
    chk(suspend_hi == 1 && suspend_lo_n == 0, "R1 suspend entered", suspend_hi, 1);

    phase = "R4";
    line_resume = 1'b1; cyc(1);
    line_resume = 1'b0; line_idle = 1'b0; cyc(1);
    chk(suspend_hi == 1, "R8 sync latency not yet", suspend_hi, 1);
    cyc(1);
    chk(suspend_hi == 0, "R4 R8 resume releases on third edge", suspend_hi, 0);
    cyc(4);

    phase = "R5";
    go_suspend();
    chk(suspend_hi == 1, "R5 suspended before bus reset", suspend_hi, 1);
    line_reset = 1'b1; cyc(2);
    line_reset = 1'b0; cyc(4);
    chk(suspend_hi == 0, "R5 bus reset releases", suspend_hi, 0);

    phase = "R6";
    wake_req = 1'b1; cyc(3);
    wake_req = 1'b0; cyc(2);
    chk(resume_drive == 0 && suspend_hi == 0, "R6 wake ignored when active", resume_drive, 0);
    go_suspend();
    resume_ms = 4'd2; wake_req = 1'b1; cyc(1);
    wake_req = 1'b0; resume_ms = 4'd15;
    chk(suspend_hi == 0, "R6 wake releases indication", suspend_hi, 0);
    count_drive(40, n);
    chk(n == 2 * PERMS, "R6 R9 drive length latched", n, 2 * PERMS);
    chk(suspend_hi == 0 && resume_drive == 0, "R6 active after drive", suspend_hi, 0);
    go_suspend();
    resume_ms = 4'd0; wake_req = 1'b1; cyc(1);
    wake_req = 1'b0;
    count_drive(20, n);
    chk(n == PERMS, "R6 zero length widened", n, PERMS);

    phase = "R10";
    go_suspend();
    resume_ms = 4'd5; wake_req = 1'b1; cyc(1);
    wake_req = 1'b0; cyc(3);
    chk(resume_drive == 1, "R10 driving before abort", resume_drive, 1);
    line_reset = 1'b1; cyc(1);
    line_reset = 1'b0; cyc(4);
    chk(resume_drive == 0 && suspend_hi == 0, "R10 bus reset ends drive", resume_drive, 0);

    phase = "R7";
    ext_rst_n = 1'b0; cyc(RMIN - 3);
    ext_rst_n = 1'b1; cyc(6);
    chk(suspend_hi == 0, "R7 short pulse ignored", suspend_hi, 0);
    ext_rst_n = 1'b0; cyc(RMIN + 6);
    chk(suspend_hi == 1, "R7 qualified reset suspends", suspend_hi, 1);
    ext_rst_n = 1'b1; cyc(6);
    chk(suspend_hi == 0, "R7 release with config present", suspend_hi, 0);

    phase = "R3";
    cfg_done = 1'b0;
    ext_rst_n = 1'b0; cyc(RMIN + 6);
    ext_rst_n = 1'b1; cyc(10);
    chk(suspend_hi == 1, "R3 held after device reset", suspend_hi, 1);
    cfg_done = 1'b1; cyc(3);
    chk(suspend_hi == 0, "R3 config after device reset", suspend_hi, 0);

    cyc(2);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule